// File: doc/BRIEF.md
# DMA Channel Address and Count Generator

This block holds the address and count state of one legacy-style DMA channel. A 16-bit current address combines with an 8-bit page value to form a 24-bit bus address, and a transfer count steps down by one on each accepted transfer. The transfer on which the count passes from zero to all-ones is the terminal one. On that transfer the channel either restores its starting address and count or masks itself.

The transfer unit is fixed for each instance by a parameter. A byte channel moves one byte per transfer. A word channel counts 16-bit words and shifts the current address left by one bit, so that it selects a word. Software programs the channel through three write ports: base address, base count and page. A fourth write port sets the mode, which is the address direction and automatic reload. A transfer strobe from the surrounding controller advances the channel, and the block drives the bus address, the byte lanes, a terminal-count flag and the mask state.

Top module: `dma_addr_chan`

## Requirements
- R1: After reset the bus address is 0, `tc` is 0 and `masked` is 1.
- R2: In byte mode `bus_addr` = {page, current address}. `byte_en` is 2'b01 when address bit 0 is 0 and 2'b10 when it is 1.
- R3: In word mode `bus_addr` = {page[7:1], current address, 1'b0} and `byte_en` is 2'b11.
- R4: A write to the base address or base count also loads the current register. The new address appears on `bus_addr` the cycle after the write.
- R5: Each accepted transfer steps the current address by one, upward when the mode direction bit is 0 and downward when it is 1.
- R6: The count is programmed as N-1. `tc` is high, in the same cycle as the strobe, on the N-th accepted transfer: the one made while the count is 0.
- R7: When the 16-bit current address wraps in either direction, the page is left unchanged.
- R8: When automatic reload is on, the terminal transfer restores the current address and count from their base values. The channel stays unmasked.
- R9: When automatic reload is off, the terminal transfer sets `masked`. A masked channel ignores the strobe: the address does not move and `tc` stays low.
- R10: A mode write sets the direction bit and the reload bit, and it clears `masked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_addr_we | input | 1 | Write strobe for the base and current address |
| base_addr_wdata | input | 16 | Start address |
| base_cnt_we | input | 1 | Write strobe for the base and current count |
| base_cnt_wdata | input | 16 | Transfer count minus one |
| page_we | input | 1 | Write strobe for the page |
| page_wdata | input | 8 | Upper address bits |
| mode_we | input | 1 | Write strobe for the mode; also unmasks the channel |
| mode_dec | input | 1 | Direction: 1 steps the address down |
| mode_autoinit | input | 1 | 1 reloads the base values at terminal count |
| xfer | input | 1 | Transfer strobe, one transfer per cycle |
| bus_addr | output | 24 | Bus address |
| byte_en | output | 2 | Active byte lanes |
| tc | output | 1 | Terminal count, high during the terminal transfer |
| masked | output | 1 | Channel masked; strobes are ignored |

## Verification
A wrong current address shows on `bus_addr` one cycle after the transfer that corrupted it. A wrong count is not visible directly. It shows as `tc` firing on the wrong transfer, which can be up to N strobes later, so the tests use short counts to keep that delay small. A wrong mask or reload decision shows in the cycle after the terminal transfer: a masked channel ignores the strobe, and after a reload the address jumps back to its base value. A page that changes when the address wraps shows in the upper address bits right after the wrapping transfer.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

   typedef enum logic {
      SIZE_BYTE = 1'b0,
      SIZE_WORD = 1'b1
   } xfer_size_e;

   typedef struct packed {
      logic dec;
      logic auto_init;
   } chan_mode_t;

   localparam chan_mode_t MODE_RESET = '{dec: 1'b0, auto_init: 1'b0};

endpackage

// File: rtl/dma_cur_reg.sv
// Base/current register pair. A write loads both registers. An accepted
// step moves the current value by one, or restores it from the base value.
module dma_cur_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_we,
   input  logic [W-1:0] load_data,
   input  logic         step_en,
   input  logic         step_dn,
   input  logic         reload,
   output logic [W-1:0] base_q,
   output logic [W-1:0] cur_q
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cur_d;

   always_comb begin
      cur_d = cur_q;
      if (load_we)
         cur_d = load_data;
      else if (step_en && reload)
         cur_d = base_q;
      else if (step_en)
         cur_d = step_dn ? (cur_q - ONE) : (cur_q + ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else begin
         if (load_we)
            base_q <= load_data;
         cur_q <= cur_d;
      end
   end
endmodule

// File: rtl/dma_bus_map.sv
// Forms the bus address and byte lanes for the transfer unit fixed by WORD_MODE.
module dma_bus_map #(
   parameter int ADDR_W    = 16,
   parameter int PAGE_W    = 8,
   parameter bit WORD_MODE = 1'b0,
   localparam int BUS_W    = ADDR_W + PAGE_W
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [PAGE_W-1:0] page,
   output logic [BUS_W-1:0]  bus_addr,
   output logic [1:0]        byte_en
);
   generate
      if (WORD_MODE) begin : g_word
         assign bus_addr = {page[PAGE_W-1:1], cur_addr, 1'b0};
         assign byte_en  = 2'b11;
      end else begin : g_byte
         assign bus_addr = {page, cur_addr};
         assign byte_en  = cur_addr[0] ? 2'b10 : 2'b01;
      end
   endgenerate
endmodule

// File: rtl/dma_chan_ctrl.sv
// Holds the mode and the mask, and decides which strobes are accepted
// and what happens at terminal count.
module dma_chan_ctrl
   import dma_addr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_we,
   input  chan_mode_t mode_wdata,
   input  logic       xfer,
   input  logic       cnt_zero,
   output chan_mode_t mode_q,
   output logic       masked,
   output logic       accept,
   output logic       tc,
   output logic       reload
);
   logic mask_q;

   assign accept = xfer && !mask_q;
   assign tc     = accept && cnt_zero;
   assign reload = tc && mode_q.auto_init;
   assign masked = mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         mask_q <= 1'b1;
      end else begin
         if (mode_we) begin
            mode_q <= mode_wdata;
            mask_q <= 1'b0;
         end else if (tc && !mode_q.auto_init) begin
            mask_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dma_addr_chan.sv
module dma_addr_chan
   import dma_addr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int PAGE_W    = 8,
   parameter int CNT_W     = 16,
   parameter bit WORD_MODE = 1'b0,
   localparam int BUS_W    = ADDR_W + PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_addr_we,
   input  logic [ADDR_W-1:0] base_addr_wdata,
   input  logic              base_cnt_we,
   input  logic [CNT_W-1:0]  base_cnt_wdata,
   input  logic              page_we,
   input  logic [PAGE_W-1:0] page_wdata,
   input  logic              mode_we,
   input  logic              mode_dec,
   input  logic              mode_autoinit,
   input  logic              xfer,
   output logic [BUS_W-1:0]  bus_addr,
   output logic [1:0]        byte_en,
   output logic              tc,
   output logic              masked
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (PAGE_W < 2) begin : g_bad_page
         $error("PAGE_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   chan_mode_t        mode_q;
   chan_mode_t        mode_wdata;
   logic              accept;
   logic              reload;
   logic              cnt_zero;
   logic [ADDR_W-1:0] base_addr_q, cur_addr_q;
   logic [CNT_W-1:0]  base_cnt_q, cur_cnt_q;
   logic [PAGE_W-1:0] page_q;

   assign mode_wdata = '{dec: mode_dec, auto_init: mode_autoinit};
   assign cnt_zero   = (cur_cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       page_q <= '0;
      else if (page_we) page_q <= page_wdata;
   end

   dma_chan_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_we    (mode_we),
      .mode_wdata (mode_wdata),
      .xfer       (xfer),
      .cnt_zero   (cnt_zero),
      .mode_q     (mode_q),
      .masked     (masked),
      .accept     (accept),
      .tc         (tc),
      .reload     (reload)
   );

   dma_cur_reg #(.W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_we   (base_addr_we),
      .load_data (base_addr_wdata),
      .step_en   (accept),
      .step_dn   (mode_q.dec),
      .reload    (reload),
      .base_q    (base_addr_q),
      .cur_q     (cur_addr_q)
   );

   dma_cur_reg #(.W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_we   (base_cnt_we),
      .load_data (base_cnt_wdata),
      .step_en   (accept),
      .step_dn   (1'b1),
      .reload    (reload),
      .base_q    (base_cnt_q),
      .cur_q     (cur_cnt_q)
   );

   dma_bus_map #(
      .ADDR_W    (ADDR_W),
      .PAGE_W    (PAGE_W),
      .WORD_MODE (WORD_MODE)
   ) u_map (
      .cur_addr (cur_addr_q),
      .page     (page_q),
      .bus_addr (bus_addr),
      .byte_en  (byte_en)
   );
endmodule

// File: rtl/dma_addr_chan_chk.sv
module dma_addr_chan_chk #(
   parameter int ADDR_W    = 16,
   parameter int PAGE_W    = 8,
   parameter int CNT_W     = 16,
   parameter bit WORD_MODE = 1'b0
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     xfer,
   input logic                     tc,
   input logic                     masked,
   input logic                     mode_we,
   input logic                     base_addr_we,
   input logic                     base_cnt_we,
   input logic                     page_we,
   input logic                     dir_dec,
   input logic                     auto_init,
   input logic [ADDR_W-1:0]        cur_addr,
   input logic [CNT_W-1:0]         cur_cnt,
   input logic [CNT_W-1:0]         base_cnt,
   input logic [PAGE_W-1:0]        page,
   input logic [ADDR_W+PAGE_W-1:0] bus_addr
);
   localparam logic [ADDR_W-1:0] A1 = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  C1 = CNT_W'(1);

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !masked && !tc && !base_addr_we) |=>
      cur_addr == ($past(dir_dec) ? $past(cur_addr) - A1 : $past(cur_addr) + A1));

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !masked && !tc && !base_cnt_we) |=> cur_cnt == $past(cur_cnt) - C1);

   // R8
   reload_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && auto_init && !base_cnt_we) |=> cur_cnt == $past(base_cnt));

   // R9
   mask_on_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && !auto_init && !mode_we) |=> masked);

   // R9
   masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (masked && !mode_we && !base_addr_we) |=> $stable(cur_addr));

   // R10
   unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we |=> !masked);

   // R7
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !page_we |=> $stable(page));

   generate
      if (WORD_MODE) begin : g_word_chk
         // R3
         word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_addr[0] == 1'b0);
      end
   endgenerate
endmodule

bind dma_addr_chan dma_addr_chan_chk #(
   .ADDR_W    (ADDR_W),
   .PAGE_W    (PAGE_W),
   .CNT_W     (CNT_W),
   .WORD_MODE (WORD_MODE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .xfer         (xfer),
   .tc           (tc),
   .masked       (masked),
   .mode_we      (mode_we),
   .base_addr_we (base_addr_we),
   .base_cnt_we  (base_cnt_we),
   .page_we      (page_we),
   .dir_dec      (mode_q.dec),
   .auto_init    (mode_q.auto_init),
   .cur_addr     (cur_addr_q),
   .cur_cnt      (cur_cnt_q),
   .base_cnt     (base_cnt_q),
   .page         (page_q),
   .bus_addr     (bus_addr)
);

// File: tb/dma_addr_chan_bench.sv
module dma_addr_chan_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_addr_we = 1'b0;
   logic [15:0] base_addr_wdata = '0;
   logic        base_cnt_we = 1'b0;
   logic [15:0] base_cnt_wdata = '0;
   logic        page_we = 1'b0;
   logic [7:0]  page_wdata = '0;
   logic        mode_we = 1'b0;
   logic        mode_dec = 1'b0;
   logic        mode_autoinit = 1'b0;
   logic        xfer = 1'b0;

   logic [23:0] b_addr, w_addr;
   logic [1:0]  b_be, w_be;
   logic        b_tc, w_tc, b_mask, w_mask;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dma_addr_chan #(.WORD_MODE(1'b0)) u_dma_addr_chan (
      .clk(clk), .rst_n(rst_n),
      .base_addr_we(base_addr_we), .base_addr_wdata(base_addr_wdata),
      .base_cnt_we(base_cnt_we), .base_cnt_wdata(base_cnt_wdata),
      .page_we(page_we), .page_wdata(page_wdata),
      .mode_we(mode_we), .mode_dec(mode_dec), .mode_autoinit(mode_autoinit),
      .xfer(xfer), .bus_addr(b_addr), .byte_en(b_be), .tc(b_tc), .masked(b_mask)
   );

   dma_addr_chan #(.WORD_MODE(1'b1)) u_dma_addr_chan_w (
      .clk(clk), .rst_n(rst_n),
      .base_addr_we(base_addr_we), .base_addr_wdata(base_addr_wdata),
      .base_cnt_we(base_cnt_we), .base_cnt_wdata(base_cnt_wdata),
      .page_we(page_we), .page_wdata(page_wdata),
      .mode_we(mode_we), .mode_dec(mode_dec), .mode_autoinit(mode_autoinit),
      .xfer(xfer), .bus_addr(w_addr), .byte_en(w_be), .tc(w_tc), .masked(w_mask)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_addr(input logic [15:0] v);
      base_addr_we = 1'b1; base_addr_wdata = v; tick(); base_addr_we = 1'b0;
   endtask
   task automatic wr_cnt(input logic [15:0] v);
      base_cnt_we = 1'b1; base_cnt_wdata = v; tick(); base_cnt_we = 1'b0;
   endtask
   task automatic wr_page(input logic [7:0] v);
      page_we = 1'b1; page_wdata = v; tick(); page_we = 1'b0;
   endtask
   task automatic wr_mode(input logic dec, input logic ai);
      mode_we = 1'b1; mode_dec = dec; mode_autoinit = ai; tick(); mode_we = 1'b0;
   endtask

   // One strobe; tc is checked while the strobe is high, before the edge.
   task automatic xfer_one(input string req, input logic exp_tc);
      xfer = 1'b1;
      #1;
      chk(req, {31'd0, b_tc}, {31'd0, exp_tc});
      chk(req, {31'd0, w_tc}, {31'd0, exp_tc});
      @(posedge clk);
      #1;
      xfer = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 addr", {8'd0, b_addr}, 32'd0);
      chk("R1 tc", {31'd0, b_tc}, 32'd0);
      chk("R1 masked", {31'd0, b_mask}, 32'd1);
      chk("R1 word masked", {31'd0, w_mask}, 32'd1);
      xfer_one("R9 masked tc", 1'b0);
      chk("R9 masked addr", {8'd0, b_addr}, 32'd0);
   endtask

   task automatic t_map();
      wr_page(8'hA5);
      wr_addr(16'h1234);
      chk("R4 addr load", {8'd0, b_addr}, 32'hA51234);
      chk("R2 byte_en even", {30'd0, b_be}, 32'h1);
      chk("R3 word addr", {8'd0, w_addr}, 32'hA42468);
      chk("R3 word byte_en", {30'd0, w_be}, 32'h3);
      wr_mode(1'b0, 1'b0);
      chk("R10 unmask", {31'd0, b_mask}, 32'd0);
   endtask

   task automatic t_inc_stop();
      wr_cnt(16'd2);
      xfer_one("R6 tc early", 1'b0);
      chk("R5 inc", {8'd0, b_addr}, 32'hA51235);
      chk("R2 byte_en odd", {30'd0, b_be}, 32'h2);
      chk("R3 word inc", {8'd0, w_addr}, 32'hA4246A);
      xfer_one("R6 tc early", 1'b0);
      chk("R5 inc", {8'd0, b_addr}, 32'hA51236);
      xfer_one("R6 tc at N", 1'b1);
      chk("R5 inc last", {8'd0, b_addr}, 32'hA51237);
      chk("R9 mask set", {31'd0, b_mask}, 32'd1);
      xfer_one("R9 ignored tc", 1'b0);
      chk("R9 ignored addr", {8'd0, b_addr}, 32'hA51237);
   endtask

   task automatic t_dec_auto();
      wr_addr(16'h0001);
      wr_cnt(16'd1);
      wr_mode(1'b1, 1'b1);
      xfer_one("R6 tc early", 1'b0);
      chk("R5 dec", {8'd0, b_addr}, 32'hA50000);
      xfer_one("R6 tc", 1'b1);
      chk("R8 addr reload", {8'd0, b_addr}, 32'hA50001);
      chk("R8 stays unmasked", {31'd0, b_mask}, 32'd0);
      xfer_one("R8 count reloaded", 1'b0);
      chk("R8 dec after reload", {8'd0, b_addr}, 32'hA50000);
      xfer_one("R8 count reloaded tc", 1'b1);
   endtask

   task automatic t_wrap();
      wr_page(8'h10);
      wr_addr(16'hFFFF);
      wr_cnt(16'd5);
      wr_mode(1'b0, 1'b0);
      xfer_one("R7 tc", 1'b0);
      chk("R7 up wrap", {8'd0, b_addr}, 32'h100000);
      chk("R7 word up wrap", {8'd0, w_addr}, 32'h100000);
      wr_mode(1'b1, 1'b0);
      xfer_one("R7 tc", 1'b0);
      chk("R7 down wrap", {8'd0, b_addr}, 32'h10FFFF);
      chk("R7 word down wrap", {8'd0, w_addr}, 32'h11FFFE);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_map();
      t_inc_stop();
      t_dec_auto();
      t_wrap();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule